// File: doc/BRIEF.md
# Codec Response Ring Writer

This block takes responses coming back from audio codecs and stores them in a circular ring in system memory. Each response is a 32-bit word tagged with the address of the codec that sent it and a flag that says whether software asked for it. The block turns each response into an 8-byte ring entry. The first word is the response itself. The second is an extended word that carries the codec address and the unsolicited tag. Both words go out through a simple memory write port.

Software sees a small register file: the ring base, the write pointer, an interrupt count, a control register and a status register. Interrupts are coalesced. The response-interrupt status bit is raised once a programmed number of responses has been stored, or as soon as the command ring has drained. A level output, count-reached, tells the command fetcher to pause. It stays high until software clears the interrupt status, which also restarts the response count. A second, register-only path serves single commands: while its busy flag is set, the next response is captured in a register and nothing is written to memory.

Top module: `rsp_ring_writer`

## Requirements
- R1: After reset, the write pointer, response count, control, status and immediate-status registers read zero, `cnt_reached` is low, `rsp_ready` is high and no memory write is issued.
- R2: While immediate-status bit 0 (busy) is set, an accepted response is stored in the immediate-response register (address 6). Busy clears, bit 1 (valid) sets, bits 7:4 take the codec address, and no memory write is made. Writing 1 to bit 1 clears valid.
- R3: With busy clear and control bit 1 (ring enable) low, an accepted response is dropped: no memory write, and the write pointer is unchanged.
- R4: A stored response first moves the write pointer forward by one, modulo 2^PTR_W (256 by default). The response word is written at base + 8 × pointer and the extended word at base + 8 × pointer + 4.
- R5: In the extended word, bits 3:0 hold the codec address, bit 4 is 1 for an unsolicited response, and all other bits are 0.
- R6: If either write of an entry reports an error, the pointer and count stay unchanged. Status bit 2 (overrun) is then set only when control bit 2 (overrun enable) is high.
- R7: With control bit 0 (interrupt enable) high and a non-zero interrupt count N, status bit 0 sets when the N-th response since the last clear is stored, and not before.
- R8: With interrupt enable high, status bit 0 sets after any stored response that finds `corb_empty` high.
- R9: With interrupt enable low, storing responses never sets status bit 0.
- R10: `cnt_reached` is high while the count equals a non-zero interrupt count and holds there. Writing 1 to status bit 0 while it is set clears the bit, zeroes the count and drops `cnt_reached`.
- R11: A write to the write-pointer register (address 1) with bit 15 set returns the pointer to zero, so the next entry goes to slot 1.
- R12: Status bits are write-one-to-clear. Writing 0 to them has no effect.
- R13: While a memory write is stalled, its address and data stay stable, and `rsp_ready` stays low until both words of the entry have been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rsp_valid | input | 1 | Codec response offered |
| rsp_ready | output | 1 | Response accepted this cycle when valid |
| rsp_data | input | 32 | Response word |
| rsp_unsol | input | 1 | 1 = unsolicited response |
| rsp_cad | input | 4 | Address of the responding codec |
| corb_empty | input | 1 | Command ring has no pending commands |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory write accepted |
| mem_wr_addr | output | ADDR_W | Byte address of the write |
| mem_wr_data | output | 32 | Write data |
| mem_wr_err | input | 1 | Error for the write accepted this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 base, 1 wptr, 2 icount, 3 ctrl, 4 status, 5 imm status, 6 imm response |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cnt_reached | output | 1 | Pause request to the command fetcher |
| sts_irq | output | 1 | Response-interrupt status bit |
| sts_ovr | output | 1 | Overrun status bit |

## Verification
The assertions check cycle-level rules on every cycle: a stalled write holds its address and data, the immediate path and the disabled-ring path never touch memory, status bits stay set until cleared, and `cnt_reached` holds its level. Only the bench scenarios can show the memory contents a response sequence produces. Its scoreboard compares each written address and word against the slot arithmetic and the extended-word format. The scenarios also cover when coalescing fires by count and by ring drain, the overrun path under injected write errors, the pointer reset, and the wrap of the pointer after 256 entries.

// File: rtl/rspw_pkg.sv
package rspw_pkg;
  localparam int CAD_W         = 4;
  localparam int CTRL_IRQ_EN   = 0;
  localparam int CTRL_RING_EN  = 1;
  localparam int CTRL_OVR_EN   = 2;
  localparam int STS_IRQ       = 0;
  localparam int STS_OVR       = 2;
  localparam int IMM_BUSY      = 0;
  localparam int IMM_VALID     = 1;
  localparam int WP_RST_BIT    = 15;
  localparam int EXT_UNSOL_BIT = 4;

  typedef enum logic [2:0] {
    RA_BASE = 3'd0, RA_WPTR = 3'd1, RA_ICNT = 3'd2, RA_CTRL = 3'd3,
    RA_STAT = 3'd4, RA_IMMS = 3'd5, RA_IMMR = 3'd6, RA_NONE = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] { WS_IDLE, WS_LO, WS_HI } wr_state_e;

  // Extended entry word: codec address low, unsolicited tag at bit 4.
  function automatic logic [31:0] ext_word(input logic [CAD_W-1:0] cad, input logic unsol);
    logic [31:0] w;
    w = '0;
    w[CAD_W-1:0] = cad;
    w[EXT_UNSOL_BIT] = unsol;
    return w;
  endfunction
endpackage

// File: rtl/rspw_ptr.sv
module rspw_ptr #(
  parameter int PTR_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_clr,
  input  logic             advance,
  input  logic             cnt_clr,
  input  logic [CNT_W-1:0] icnt,
  output logic [PTR_W-1:0] wp,
  output logic [PTR_W-1:0] wp_nxt,
  output logic [CNT_W-1:0] cnt_after,
  output logic             reached
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_inc;

  assign wp_nxt    = wp + 1'b1;
  assign reached   = (icnt != '0) && (cnt_q == icnt);
  assign cnt_inc   = advance && !reached && (cnt_q != CNT_MAX);
  assign cnt_after = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      cnt_q <= '0;
    end else begin
      if (wp_clr)       wp <= '0;
      else if (advance) wp <= wp_nxt;
      cnt_q <= (cnt_clr ? '0 : cnt_q) + CNT_W'(cnt_inc);
    end
  end

  p_wp_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wp_clr |=> wp == '0);
  p_wp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !wp_clr |=> wp == PTR_W'($past(wp) + 1'b1));
  p_cnt_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr && !advance |=> cnt_q == '0);
endmodule

// File: rtl/rspw_status.sv
module rspw_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_irq,
  input  logic set_ovr,
  input  logic clr_irq,
  input  logic clr_ovr,
  output logic sts_irq,
  output logic sts_ovr,
  output logic irq_cleared
);
  assign irq_cleared = sts_irq && clr_irq && !set_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_irq <= 1'b0;
      sts_ovr <= 1'b0;
    end else begin
      if (set_irq)      sts_irq <= 1'b1;
      else if (clr_irq) sts_irq <= 1'b0;
      if (set_ovr)      sts_ovr <= 1'b1;
      else if (clr_ovr) sts_ovr <= 1'b0;
    end
  end

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_irq && !clr_irq |=> sts_irq);
  p_ovr_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sts_ovr && !clr_ovr |=> sts_ovr);
  p_irq_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_irq && !set_irq |=> !sts_irq);
endmodule

// File: rtl/rsp_ring_writer.sv
module rsp_ring_writer import rspw_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [31:0]       rsp_data,
  input  logic              rsp_unsol,
  input  logic [CAD_W-1:0]  rsp_cad,
  input  logic              corb_empty,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  input  logic              mem_wr_err,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              cnt_reached,
  output logic              sts_irq,
  output logic              sts_ovr
);
  localparam int ENTRY_SHIFT = 3;

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [PTR_W-1:0]  p,
                                                  input logic              hi);
    return b + (ADDR_W'(p) << ENTRY_SHIFT) + (hi ? ADDR_W'(4) : '0);
  endfunction

  // software registers
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  icnt_q;
  logic [2:0]        ctrl_q;
  logic              imm_busy, imm_valid;
  logic [CAD_W-1:0]  imm_cad;
  logic [31:0]       imm_rsp;

  // entry staging
  wr_state_e   state_q;
  logic [31:0] rsp_q, ext_q;
  logic        err_q;

  // named events
  logic rsp_fire, take_imm, take_drop, take_mem, mem_fire, commit, wfail;
  logic stored, ovr_evt, irq_evt, wp_clr, cnt_clr;
  logic wr_base, wr_wptr, wr_icnt, wr_ctrl, wr_stat, wr_imms;
  logic [PTR_W-1:0] wp, wp_nxt;
  logic [CNT_W-1:0] cnt_after;
  reg_sel_e sel;

  assign sel     = reg_sel_e'(reg_addr);
  assign wr_base = reg_wr && sel == RA_BASE;
  assign wr_wptr = reg_wr && sel == RA_WPTR;
  assign wr_icnt = reg_wr && sel == RA_ICNT;
  assign wr_ctrl = reg_wr && sel == RA_CTRL;
  assign wr_stat = reg_wr && sel == RA_STAT;
  assign wr_imms = reg_wr && sel == RA_IMMS;

  assign rsp_ready = (state_q == WS_IDLE);
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign take_imm  = rsp_fire && imm_busy;
  assign take_drop = rsp_fire && !imm_busy && !ctrl_q[CTRL_RING_EN];
  assign take_mem  = rsp_fire && !imm_busy && ctrl_q[CTRL_RING_EN];

  assign mem_wr_valid = (state_q != WS_IDLE);
  assign mem_fire     = mem_wr_valid && mem_wr_ready;
  assign mem_wr_addr  = slot_addr(base_q, wp_nxt, state_q == WS_HI);
  assign mem_wr_data  = (state_q == WS_HI) ? ext_q : rsp_q;

  assign commit  = (state_q == WS_HI) && mem_fire;
  assign wfail   = err_q || mem_wr_err;
  assign stored  = commit && !wfail;
  assign ovr_evt = commit && wfail && ctrl_q[CTRL_OVR_EN];
  assign irq_evt = stored && ctrl_q[CTRL_IRQ_EN] &&
                   (((icnt_q != '0) && (cnt_after == icnt_q)) || corb_empty);
  assign wp_clr  = wr_wptr && reg_wdata[WP_RST_BIT];

  rspw_ptr #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wp_clr(wp_clr), .advance(stored),
    .cnt_clr(cnt_clr), .icnt(icnt_q), .wp(wp), .wp_nxt(wp_nxt),
    .cnt_after(cnt_after), .reached(cnt_reached)
  );

  rspw_status u_status (
    .clk(clk), .rst_n(rst_n), .set_irq(irq_evt), .set_ovr(ovr_evt),
    .clr_irq(wr_stat && reg_wdata[STS_IRQ]), .clr_ovr(wr_stat && reg_wdata[STS_OVR]),
    .sts_irq(sts_irq), .sts_ovr(sts_ovr), .irq_cleared(cnt_clr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      rsp_q   <= '0;
      ext_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        WS_IDLE: if (take_mem) begin
          state_q <= WS_LO;
          rsp_q   <= rsp_data;
          ext_q   <= ext_word(rsp_cad, rsp_unsol);
          err_q   <= 1'b0;
        end
        WS_LO: if (mem_fire) begin
          state_q <= WS_HI;
          err_q   <= mem_wr_err;
        end
        WS_HI: if (mem_fire) state_q <= WS_IDLE;
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      icnt_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_base) base_q <= {reg_wdata[ADDR_W-1:ENTRY_SHIFT], {ENTRY_SHIFT{1'b0}}};
      if (wr_icnt) icnt_q <= reg_wdata[CNT_W-1:0];
      if (wr_ctrl) ctrl_q <= reg_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_busy  <= 1'b0;
      imm_valid <= 1'b0;
      imm_cad   <= '0;
      imm_rsp   <= '0;
    end else if (take_imm) begin
      imm_busy  <= 1'b0;
      imm_valid <= 1'b1;
      imm_cad   <= rsp_cad;
      imm_rsp   <= rsp_data;
    end else if (wr_imms) begin
      if (reg_wdata[IMM_BUSY])  imm_busy  <= 1'b1;
      if (reg_wdata[IMM_VALID]) imm_valid <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      RA_BASE: reg_rdata = 32'(base_q);
      RA_WPTR: reg_rdata = 32'(wp);
      RA_ICNT: reg_rdata = 32'(icnt_q);
      RA_CTRL: reg_rdata = 32'(ctrl_q);
      RA_STAT: begin
        reg_rdata[STS_IRQ] = sts_irq;
        reg_rdata[STS_OVR] = sts_ovr;
      end
      RA_IMMS: begin
        reg_rdata[IMM_BUSY]  = imm_busy;
        reg_rdata[IMM_VALID] = imm_valid;
        reg_rdata[4 +: CAD_W] = imm_cad;
      end
      RA_IMMR: reg_rdata = imm_rsp;
      default: reg_rdata = '0;
    endcase
  end

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready && !wp_clr |=>
      mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));
  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_mem |=> mem_wr_valid && !rsp_ready);
  p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_drop |=> !mem_wr_valid && $stable(wp));
  p_imm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_imm |=> imm_valid && !imm_busy && !mem_wr_valid && imm_cad == $past(rsp_cad));
  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CTRL_IRQ_EN] && !sts_irq |=> !sts_irq);
  p_reached_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_reached && !cnt_clr && !wr_icnt |=> cnt_reached);
  p_unused_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit && wfail |=> $stable(wp));
endmodule

// File: tb/test_rsp_ring_writer.sv
`timescale 1ns/1ps
module test_rsp_ring_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rsp_valid = 1'b0, rsp_unsol = 1'b0, corb_empty = 1'b0;
  logic [31:0] rsp_data = '0;
  logic [3:0]  rsp_cad = '0;
  logic        rsp_ready;
  logic        mem_wr_valid, mem_wr_ready = 1'b0, mem_wr_err = 1'b0;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        cnt_reached, sts_irq, sts_ovr;

  int errors = 0, checks = 0, stall = 0;
  bit err_mode = 0, done = 0;
  logic [7:0] exp_wp = '0;
  logic [31:0] base = 32'h0000_1000;
  logic [31:0] qa[$], qd[$], rv;

  always #2 clk = ~clk;

  rsp_ring_writer i_rsp_ring_writer (
    .clk, .rst_n, .rsp_valid, .rsp_ready, .rsp_data, .rsp_unsol, .rsp_cad,
    .corb_empty, .mem_wr_valid, .mem_wr_ready, .mem_wr_addr, .mem_wr_data,
    .mem_wr_err, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .cnt_reached,
    .sts_irq, .sts_ovr
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory side: stall one cycle in three, error when err_mode
  initial forever begin
    @(posedge clk); #1;
    stall++;
    mem_wr_ready = (stall % 3) != 0;
    mem_wr_err   = err_mode;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_wr_valid && mem_wr_ready) begin
      if (qa.size() == 0) chk("R3 unexpected memory write", mem_wr_addr, 32'hFFFF_FFFF);
      else begin
        logic [31:0] ea, ed;
        ea = qa.pop_front();
        ed = qd.pop_front();
        chk("R4 entry address", mem_wr_addr, ea);
        chk(ea[2] ? "R5 extended word" : "R4 response word", mem_wr_data, ed);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #0.5 d = reg_rdata;
  endtask

  // to_mem: entry expected in memory; adv: pointer expected to advance
  task automatic send(input logic [31:0] d, input bit u, input logic [3:0] c,
                      input bit to_mem, input bit adv);
    logic [7:0] slot;
    slot = exp_wp + 8'd1;
    if (to_mem) begin
      qa.push_back(base + 32'(slot) * 8);     qd.push_back(d);
      qa.push_back(base + 32'(slot) * 8 + 4); qd.push_back({27'b0, u, c});
      if (adv) exp_wp = slot;
    end
    @(negedge clk); rsp_valid = 1'b1; rsp_data = d; rsp_unsol = u; rsp_cad = c;
    while (!rsp_ready) @(negedge clk);
    @(posedge clk); #1 rsp_valid = 1'b0;
    @(negedge clk);
    if (to_mem) chk("R13 ready low during write", 32'(rsp_ready), 0);
    while (!rsp_ready) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(3'd1, rv); chk("R1 wptr", rv, 0);
    rd(3'd3, rv); chk("R1 ctrl", rv, 0);
    rd(3'd4, rv); chk("R1 status", rv, 0);
    rd(3'd5, rv); chk("R1 imm status", rv, 0);
    chk("R1 cnt_reached", 32'(cnt_reached), 0);
    chk("R1 rsp_ready", 32'(rsp_ready), 1);
    chk("R1 no write", 32'(mem_wr_valid), 0);

    wr(3'd0, base); wr(3'd3, 32'h7); wr(3'd2, 32'd3);
    // R7 count coalescing
    send(32'hA000_0001, 1'b0, 4'd2, 1, 1);
    send(32'hA000_0002, 1'b1, 4'd9, 1, 1);
    rd(3'd4, rv); chk("R7 no irq before count", rv, 0);
    chk("R10 not reached yet", 32'(cnt_reached), 0);
    send(32'hA000_0003, 1'b1, 4'd15, 1, 1);
    rd(3'd4, rv); chk("R7 irq at count", rv, 1);
    chk("R10 reached", 32'(cnt_reached), 1);
    rd(3'd1, rv); chk("R4 wptr after three", rv, 3);
    repeat (3) @(negedge clk);
    chk("R10 reached held", 32'(cnt_reached), 1);
    wr(3'd4, 32'h1);
    rd(3'd4, rv); chk("R10 status cleared", rv, 0);
    chk("R10 reached dropped", 32'(cnt_reached), 0);

    // R8 ring drained
    wr(3'd2, 32'd0); corb_empty = 1'b1;
    send(32'hB000_0001, 1'b0, 4'd1, 1, 1);
    rd(3'd4, rv); chk("R8 irq on ring empty", rv, 1);
    wr(3'd4, 32'h1);

    // R9 interrupt disabled
    wr(3'd3, 32'h6);
    send(32'hB000_0002, 1'b0, 4'd3, 1, 1);
    rd(3'd4, rv); chk("R9 no irq when disabled", rv, 0);
    corb_empty = 1'b0;

    // R3 ring disabled
    wr(3'd3, 32'h4);
    send(32'hC000_0001, 1'b0, 4'd4, 0, 0);
    rd(3'd1, rv); chk("R3 wptr unchanged", rv, 32'(exp_wp));

    // R2 immediate path
    wr(3'd3, 32'h7); wr(3'd5, 32'h1);
    send(32'hCAFE_F00D, 1'b0, 4'd5, 0, 0);
    rd(3'd5, rv); chk("R2 imm status", rv, 32'h52);
    rd(3'd6, rv); chk("R2 imm response", rv, 32'hCAFE_F00D);
    rd(3'd1, rv); chk("R2 wptr unchanged", rv, 32'(exp_wp));
    wr(3'd5, 32'h2);
    rd(3'd5, rv); chk("R2 valid cleared", rv, 32'h50);

    // R6 write error with overrun enabled
    err_mode = 1;
    send(32'hD000_0001, 1'b1, 4'd6, 1, 0);
    rd(3'd4, rv); chk("R6 overrun set", rv, 4);
    rd(3'd1, rv); chk("R6 wptr unchanged", rv, 32'(exp_wp));
    wr(3'd4, 32'h0);
    rd(3'd4, rv); chk("R12 write zero no effect", rv, 4);
    wr(3'd4, 32'h4);
    rd(3'd4, rv); chk("R12 overrun cleared", rv, 0);
    wr(3'd3, 32'h3);
    send(32'hD000_0002, 1'b0, 4'd6, 1, 0);
    rd(3'd4, rv); chk("R6 no overrun when disabled", rv, 0);
    err_mode = 0;

    // R11 pointer reset
    wr(3'd1, 32'h0000_8000);
    rd(3'd1, rv); chk("R11 wptr reset", rv, 0);
    exp_wp = '0;
    send(32'hE000_0001, 1'b0, 4'd7, 1, 1);
    rd(3'd1, rv); chk("R11 next slot one", rv, 1);

    // R4 pointer wrap after 256 entries
    wr(3'd3, 32'h2);
    for (int i = 0; i < 256; i++) send(32'hF000_0000 + 32'(i), i[0], 4'(i), 1, 1);
    rd(3'd1, rv); chk("R4 wptr wrapped", rv, 1);
    chk("R4 scoreboard drained", 32'(qa.size()), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule